// File: doc/BRIEF.md
# Center-Marked Palindrome Recognizer

This block is a deterministic pushdown automaton. It reads a stream of symbols, one per clock, and decides whether the whole stream has the shape w c reverse(w), where w is any binary string. The symbol alphabet is {0, 1, c}. A finite-state control works with an on-chip stack. Every transition is chosen by the current control state, the incoming symbol and the symbol on top of the stack, all three together. The empty stack stands for the bottom marker. In the matching phase, seeing that marker triggers a move that reads no input and that alone leads to acceptance.

Symbols arrive on a valid/ready stream. A separate end-of-stream flag asks for the verdict. The block then raises either an accept output or a reject output and holds it until a synchronous reset. An overflow flag reports that a push found the stack already full.

Top module: `pal_pda`

## Requirements
- R1: During and after a synchronous reset, ready is high and acc, rej and ovf are all low. The stack holds only the bottom marker and control is in the push phase.
- R2: Symbol codes are 00 for '0', 01 for '1', 10 for 'c' and 11 reserved. In the push phase, '0' and '1' are pushed without popping, and 'c' moves control to the matching phase with the stack left unchanged.
- R3: In the matching phase, a '0' or '1' that equals the top of stack pops one entry. A mismatching symbol, or a 'c', sends control to a sticky reject state.
- R4: In the matching phase, when the bottom marker is on top, ready is low for exactly one cycle and control then moves to the accepting state without consuming input.
- R5: A reserved code (11) accepted in the push or matching phase sends control to the reject state.
- R6: Any symbol accepted after the accepting state is reached sends control to the reject state.
- R7: The stack holds DEPTH entries (default 64). A stream that pushes exactly DEPTH symbols is still handled normally. A push into a full stack sets ovf, which stays high until reset, and rejects.
- R8: The end flag is taken only in a cycle with ready high. On the next edge, acc rises if control was in the accepting state and rej rises otherwise. A symbol presented with valid in that same cycle is not consumed.
- R9: After a verdict, ready stays low and acc and rej keep their values until reset. acc and rej are never high together.
- R10: A cycle with valid low and the end flag low leaves control and stack unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| sym_valid | input | 1 | A symbol is presented on sym_data |
| sym_ready | output | 1 | The block can take a symbol or the end flag this cycle |
| sym_data | input | 2 | Symbol code: 00 '0', 01 '1', 10 'c', 11 reserved |
| eoi | input | 1 | End of stream: asks for the verdict |
| acc | output | 1 | Registered verdict: stream accepted |
| rej | output | 1 | Registered verdict: stream rejected |
| ovf | output | 1 | Registered flag: a push found the stack full |

## Verification
On every cycle, the assertions check that acc and rej never rise together, that a verdict holds with ready low, that ovf is sticky and never appears with acc, that a taken end flag yields a verdict on the next edge, that a ready-low stall before a verdict lasts exactly one cycle, and the output state after reset. Only the bench's scenarios can show which verdict is correct for a given stream. This covers pushes and matched pops, the one-cycle marker move after the centre, mismatched halves, streams with no centre, reserved codes, symbols after acceptance, the full-stack boundary and overflow. The bench compares the block against a queue-based model on every clock.

// File: rtl/pal_pkg.sv
package pal_pkg;
  typedef enum logic [1:0] {
    SYM_ZERO = 2'b00,
    SYM_ONE  = 2'b01,
    SYM_MID  = 2'b10,
    SYM_RSV  = 2'b11
  } sym_e;

  typedef enum logic [1:0] {
    ST_PUSH   = 2'd0,
    ST_MATCH  = 2'd1,
    ST_ACCEPT = 2'd2,
    ST_REJECT = 2'd3
  } ctl_e;
endpackage

// File: rtl/pal_stack.sv
module pal_stack #(
  parameter int DEPTH = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic push,
  input  logic pop,
  input  logic push_bit,
  output logic top_bit,
  output logic empty,
  output logic full
);
  localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W  = $clog2(DEPTH + 1);

  logic              mem [DEPTH];
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  top_idx;

  assign empty   = (cnt == '0);
  assign full    = (cnt == CNT_W'(DEPTH));
  assign top_idx = cnt - CNT_W'(1);
  assign top_bit = mem[top_idx[ADDR_W-1:0]];

  // storage: plain write port, no reset, suitable for RAM inference
  always_ff @(posedge clk) begin
    if (push && !full) begin
      mem[cnt[ADDR_W-1:0]] <= push_bit;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (push && !full) begin
      cnt <= cnt + CNT_W'(1);
    end else if (pop && !empty) begin
      cnt <= cnt - CNT_W'(1);
    end
  end
endmodule

// File: rtl/pal_ctrl.sv
module pal_ctrl
  import pal_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       sym_valid,
  input  logic [1:0] sym_data,
  input  logic       eoi,
  input  logic       top_bit,
  input  logic       empty,
  input  logic       full,
  output logic       ready,
  output logic       push,
  output logic       pop,
  output logic       push_bit,
  output logic       acc,
  output logic       rej,
  output logic       ovf
);
  ctl_e state, nxt;
  logic done;
  logic take_eoi, take_sym, ovf_set;
  sym_e sym;

  assign sym      = sym_e'(sym_data);
  assign ready    = !done && !(state == ST_MATCH && empty);
  assign take_eoi = ready && eoi;
  assign take_sym = ready && !eoi && sym_valid;
  assign push_bit = sym_data[0];

  always_comb begin
    nxt     = state;
    push    = 1'b0;
    pop     = 1'b0;
    ovf_set = 1'b0;
    if (take_sym) begin
      unique case (state)
        ST_PUSH: begin
          if (sym == SYM_ZERO || sym == SYM_ONE) begin
            if (full) begin
              nxt     = ST_REJECT;
              ovf_set = 1'b1;
            end else begin
              push = 1'b1;
            end
          end else if (sym == SYM_MID) begin
            nxt = ST_MATCH;
          end else begin
            nxt = ST_REJECT;
          end
        end
        ST_MATCH: begin
          if ((sym == SYM_ZERO || sym == SYM_ONE) && top_bit == sym_data[0]) begin
            pop = 1'b1;
          end else begin
            nxt = ST_REJECT;
          end
        end
        ST_ACCEPT: nxt = ST_REJECT;
        default:   nxt = ST_REJECT;
      endcase
    end else if (!done && state == ST_MATCH && empty) begin
      nxt = ST_ACCEPT;  // move on the bottom marker, no input read
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_PUSH;
      done  <= 1'b0;
      acc   <= 1'b0;
      rej   <= 1'b0;
      ovf   <= 1'b0;
    end else begin
      state <= nxt;
      if (ovf_set) ovf <= 1'b1;
      if (take_eoi) begin
        done <= 1'b1;
        acc  <= (state == ST_ACCEPT);
        rej  <= (state != ST_ACCEPT);
      end
    end
  end
endmodule

// File: rtl/pal_pda.sv
module pal_pda #(
  parameter int DEPTH = 64
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sym_valid,
  output logic       sym_ready,
  input  logic [1:0] sym_data,
  input  logic       eoi,
  output logic       acc,
  output logic       rej,
  output logic       ovf
);
  logic push, pop, push_bit, top_bit, empty, full;

  pal_stack #(.DEPTH(DEPTH)) u_stack (
    .clk(clk), .rst(rst), .push(push), .pop(pop), .push_bit(push_bit),
    .top_bit(top_bit), .empty(empty), .full(full)
  );

  pal_ctrl u_ctrl (
    .clk(clk), .rst(rst), .sym_valid(sym_valid), .sym_data(sym_data),
    .eoi(eoi), .top_bit(top_bit), .empty(empty), .full(full),
    .ready(sym_ready), .push(push), .pop(pop), .push_bit(push_bit),
    .acc(acc), .rej(rej), .ovf(ovf)
  );
endmodule

// File: rtl/pal_pda_chk.sv
module pal_pda_chk (
  input logic clk,
  input logic rst,
  input logic sym_ready,
  input logic eoi,
  input logic acc,
  input logic rej,
  input logic ovf
);
  a_r1_reset_state: assert property (@(posedge clk)
    $past(rst) |-> (!acc && !rej && !ovf));

  a_r9_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(acc && rej));

  a_r9_acc_hold: assert property (@(posedge clk) disable iff (rst)
    acc |=> (acc && !sym_ready));

  a_r9_rej_hold: assert property (@(posedge clk) disable iff (rst)
    rej |=> (rej && !sym_ready));

  a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    ovf |=> ovf);

  a_r7_ovf_no_acc: assert property (@(posedge clk) disable iff (rst)
    ovf |-> !acc);

  a_r8_verdict: assert property (@(posedge clk) disable iff (rst)
    (sym_ready && eoi) |=> (acc || rej));

  a_r4_one_stall: assert property (@(posedge clk) disable iff (rst)
    (!sym_ready && !acc && !rej) |=> sym_ready);
endmodule

bind pal_pda pal_pda_chk u_chk (
  .clk(clk), .rst(rst), .sym_ready(sym_ready), .eoi(eoi),
  .acc(acc), .rej(rej), .ovf(ovf)
);

// File: tb/sim_pal_pda.sv
module sim_pal_pda;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sym_valid = 1'b0;
  logic [1:0] sym_data = 2'b00;
  logic eoi = 1'b0;
  logic sym_ready, acc, rej, ovf;

  int checks = 0;
  int fails = 0;
  bit ended = 1'b0;

  // model state: 0 push, 1 match, 2 accept, 3 reject
  int m_st;
  bit m_stk[$];
  bit m_done, m_acc, m_rej, m_ovf;

  always #(CLK_PERIOD/2) clk = ~clk;

  pal_pda #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rst(rst), .sym_valid(sym_valid), .sym_ready(sym_ready),
    .sym_data(sym_data), .eoi(eoi), .acc(acc), .rej(rej), .ovf(ovf)
  );

  function automatic bit m_ready();
    return !m_done && !(m_st == 1 && m_stk.size() == 0);
  endfunction

  task automatic chk(input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", what, act, exp, $time);
    end
  endtask

  task automatic m_step(input bit v, input bit [1:0] d, input bit e, input bit rdy);
    if (rdy && e) begin
      m_done = 1'b1;
      m_acc  = (m_st == 2);
      m_rej  = (m_st != 2);
    end else if (rdy && v) begin
      case (m_st)
        0: begin
          if (d == 2'b00 || d == 2'b01) begin
            if (m_stk.size() == DEPTH) begin m_ovf = 1'b1; m_st = 3; end
            else m_stk.push_back(d[0]);
          end else if (d == 2'b10) m_st = 1;
          else m_st = 3;
        end
        1: begin
          if ((d == 2'b00 || d == 2'b01) && m_stk.size() > 0 && m_stk[$] == d[0])
            void'(m_stk.pop_back());
          else m_st = 3;
        end
        default: m_st = 3;
      endcase
    end else if (!m_done && m_st == 1 && m_stk.size() == 0) begin
      m_st = 2;
    end
  endtask

  // one clock: drive at the falling edge, compare ready, step model, compare outputs
  task automatic cyc(input bit v, input bit [1:0] d, input bit e, input string tag, output bit taken);
    bit rdy;
    sym_valid = v; sym_data = d; eoi = e;
    #1;
    rdy = m_ready();
    chk(sym_ready, rdy, {tag, " ready"});
    @(posedge clk);
    m_step(v, d, e, rdy);
    taken = rdy;
    @(negedge clk);
    chk(acc, m_acc, {tag, " acc"});
    chk(rej, m_rej, {tag, " rej"});
    chk(ovf, m_ovf, {tag, " ovf"});
  endtask

  task automatic do_reset();
    rst = 1'b1; sym_valid = 1'b0; eoi = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    m_st = 0; m_stk.delete(); m_done = 0; m_acc = 0; m_rej = 0; m_ovf = 0;
    chk(sym_ready, 1'b1, "R1 ready after reset");
    chk(acc, 1'b0, "R1 acc after reset");
    chk(rej, 1'b0, "R1 rej after reset");
    chk(ovf, 1'b0, "R1 ovf after reset");
  endtask

  task automatic put(input bit [1:0] d, input string tag);
    bit t;
    t = 1'b0;
    while (!t && !m_done) cyc(1'b1, d, 1'b0, tag, t);
  endtask

  task automatic put_str(input string s, input string tag);
    for (int i = 0; i < s.len(); i++) begin
      case (s[i])
        "0": put(2'b00, tag);
        "1": put(2'b01, tag);
        "c": put(2'b10, tag);
        default: put(2'b11, tag);
      endcase
    end
  endtask

  task automatic finish_run(input bit v, input bit [1:0] d, input string tag);
    bit t;
    t = 1'b0;
    while (!t) cyc(v, d, 1'b1, tag, t);
    cyc(1'b0, 2'b00, 1'b0, {tag, " hold"}, t);
    cyc(1'b1, 2'b01, 1'b1, {tag, " hold"}, t);
  endtask

  task automatic expect_verdict(input bit a, input string tag);
    chk(acc, a, {tag, " verdict acc"});
    chk(rej, !a, {tag, " verdict rej"});
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!ended) begin
      ended = 1'b1;
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    bit t;
    @(negedge clk);
    do_reset();

    // R2 R3 R4: the classic stream
    put_str("01010c01010", "R3 match");
    finish_run(1'b0, 2'b00, "R2");
    expect_verdict(1'b1, "R2 01010c01010");

    // R4: empty w, one-cycle stall right after the centre
    do_reset();
    put_str("c", "R4");
    cyc(1'b1, 2'b00, 1'b0, "R4 stall", t);
    chk(t, 1'b0, "R4 symbol not taken during marker move");
    finish_run(1'b0, 2'b00, "R4");
    expect_verdict(1'b1, "R4 lone centre");

    // R2: no centre symbol
    do_reset();
    put_str("0110", "R2 no centre");
    finish_run(1'b0, 2'b00, "R2");
    expect_verdict(1'b0, "R2 no centre");

    // R3: mismatched halves
    do_reset();
    put_str("011c100", "R3 mismatch");
    finish_run(1'b0, 2'b00, "R3");
    expect_verdict(1'b0, "R3 mismatch");

    // R3: second centre in match phase
    do_reset();
    put_str("1cc1", "R3 double centre");
    finish_run(1'b0, 2'b00, "R3");
    expect_verdict(1'b0, "R3 double centre");

    // R5: reserved code
    do_reset();
    put_str("0r", "R5 reserved");
    finish_run(1'b0, 2'b00, "R5");
    expect_verdict(1'b0, "R5 reserved");

    // R6: symbol after acceptance
    do_reset();
    put_str("10c01", "R6");
    cyc(1'b0, 2'b00, 1'b0, "R6 marker", t);
    put_str("0", "R6 extra");
    finish_run(1'b0, 2'b00, "R6");
    expect_verdict(1'b0, "R6 extra symbol");

    // R8: symbol with end flag in the same cycle is not consumed
    do_reset();
    put_str("0c0", "R8");
    finish_run(1'b1, 2'b01, "R8");
    expect_verdict(1'b1, "R8 symbol ignored with end");

    // R10: idle gaps change nothing
    do_reset();
    put_str("1", "R10");
    repeat (3) cyc(1'b0, 2'b11, 1'b0, "R10 idle", t);
    put_str("c", "R10");
    repeat (2) cyc(1'b0, 2'b11, 1'b0, "R10 idle", t);
    put_str("1", "R10");
    finish_run(1'b0, 2'b00, "R10");
    expect_verdict(1'b1, "R10 gaps");

    // R7: exactly full stack is fine
    do_reset();
    for (int i = 0; i < DEPTH; i++) put(2'(i % 2), "R7 fill");
    put(2'b10, "R7 centre");
    for (int i = DEPTH - 1; i >= 0; i--) put(2'(i % 2), "R7 drain");
    finish_run(1'b0, 2'b00, "R7");
    expect_verdict(1'b1, "R7 full depth");
    chk(ovf, 1'b0, "R7 no overflow at depth");

    // R7: one push too many
    do_reset();
    for (int i = 0; i <= DEPTH; i++) put(2'b01, "R7 over");
    chk(ovf, 1'b1, "R7 overflow flag");
    finish_run(1'b0, 2'b00, "R7");
    expect_verdict(1'b0, "R7 overflow");

    // random streams against the model (R2 R3 R5 R9)
    for (int n = 0; n < 60; n++) begin
      int len, mode, pos;
      bit w[$];
      do_reset();
      len = $urandom_range(0, 10);
      mode = $urandom_range(0, 3);
      for (int i = 0; i < len; i++) w.push_back(1'($urandom_range(0, 1)));
      for (int i = 0; i < len; i++) put({1'b0, w[i]}, "R2 random");
      if (mode != 2) put(2'b10, "R2 random");
      pos = (len > 0) ? $urandom_range(0, len - 1) : 0;
      for (int i = len - 1; i >= 0; i--) begin
        if (mode == 1 && i == pos) put({1'b0, !w[i]}, "R3 random");
        else if (mode == 3 && i == pos) put(2'b11, "R5 random");
        else put({1'b0, w[i]}, "R3 random");
        if ($urandom_range(0, 3) == 0) cyc(1'b0, 2'b00, 1'b0, "R10 random idle", t);
      end
      finish_run(1'b0, 2'b00, "R9 random");
      expect_verdict((mode == 0) || (mode == 1 && len == 0) || (mode == 3 && len == 0),
                     "R9 random verdict");
    end

    if (!ended) begin
      ended = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule